// File: doc/BRIEF.md
# Dual Segment Pointer Counters

This block keeps two independent one-bit segment counters. The read counter advances on data read cycles and the write counter advances on data write cycles. Each counter chooses which 32-bit half of a 64-bit internal word the 32-bit data bus reaches on the next data cycle. A counter holds a start limit, an end limit and a current pointer. It steps upward from the pointer until it reaches the end limit, and from there it returns to the start limit. The pointer may be loaded with a value outside the start-to-end range.

Two complete copies exist: a foreground set and a background set. A set-select input picks the active set. Register writes, readbacks, advances and the reset-to-start command reach only the active set. A one-cycle end strobe marks each data access that used the end-limit segment, so that a neighbouring address unit can step its address.

Top module: `segptr_bank`

## Requirements
- R1: While `rst` is high, both sets load start 0, end 1 and pointer 0 into both counters. `rd_data`, `rd_end_stb` and `wr_end_stb` clear to 0.
- R2: The control word has six field bits. Read pointer is bit 0, read start is bit 3, read end is bit 6, write pointer is bit 8, write start is bit 11 and write end is bit 13. On a `reg_rd` pulse, `rd_data[15:0]` returns the active set in the same layout one cycle later. All other bits of the low half read 0, whatever was written.
- R3: On the cycle after a `reg_rd` pulse, `rd_data[31:16]` equals the `status_hi` value that was present with the pulse.
- R4: On an advance, a pointer that differs from its end limit goes to pointer+1 modulo 2. A pointer equal to its end limit goes to the start limit. The new pointer shows on `rd_seg` or `wr_seg` after the clock edge.
- R5: `rd_adv` moves only the read counter and `wr_adv` moves only the write counter. With no advance, write or reset command, a pointer holds its value.
- R6: `rd_end_stb` (or `wr_end_stb`) is high for exactly the cycle after an advance whose pointer equalled the end limit. It is low after any other cycle.
- R7: A register write may set the pointer outside the start-to-end range. The counter then steps from that value.
- R8: `seg_rst` returns both counters of the active set to start 0, end 1 and pointer 0. The inactive set is unchanged.
- R9: `set_sel` (0 foreground, 1 background) routes writes, reads, advances and `seg_rst` to the selected set only.
- R10: When the start and end limits are equal, the pointer stays at that value from the first wrap onward. Every later advance raises the end strobe.
- R11: Priority in one cycle is `seg_rst`, then `reg_wr`, then the advance. The end strobe still reflects the state before that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| set_sel | input | 1 | Active set: 0 foreground, 1 background |
| reg_wr | input | 1 | Write the control word of the active set |
| reg_wr_data | input | 16 | Control word to write |
| reg_rd | input | 1 | Capture a readback into `rd_data` |
| status_hi | input | 16 | Upper status half returned on readback |
| rd_adv | input | 1 | A data read cycle used the read pointer |
| wr_adv | input | 1 | A data write cycle used the write pointer |
| seg_rst | input | 1 | Return active set counters to start values |
| rd_seg | output | 1 | Read pointer of the active set |
| wr_seg | output | 1 | Write pointer of the active set |
| rd_end_stb | output | 1 | Read access used the end-limit segment |
| wr_end_stb | output | 1 | Write access used the end-limit segment |
| rd_data | output | 32 | Registered readback word |

## Verification
Several kinds of state fault show up at the ports within one or two cycles. A wrong pointer shows on `rd_seg` or `wr_seg` right after the edge. A wrong limit does not show at once, but the next advance gives a wrong pointer or a missing or extra end strobe. Corruption in the inactive set stays hidden until `set_sel` changes, so the bench reads both sets after any action aimed at one. A stuck reserved bit or a misplaced field appears in `rd_data` one cycle after a read.

// File: rtl/segptr_pkg.sv
package segptr_pkg;
  typedef struct packed {
    logic start_lim;
    logic end_lim;
    logic ptr;
  } seg_ctr_t;

  localparam seg_ctr_t SEG_INIT = '{start_lim: 1'b0, end_lim: 1'b1, ptr: 1'b0};

  // control word field positions
  localparam int RD_PTR_B   = 0;
  localparam int RD_START_B = 3;
  localparam int RD_END_B   = 6;
  localparam int WR_PTR_B   = 8;
  localparam int WR_START_B = 11;
  localparam int WR_END_B   = 13;
endpackage

// File: rtl/segptr_counter.sv
module segptr_counter
  import segptr_pkg::*;
(
  input  logic     clk,
  input  logic     rst,
  input  logic     clr,
  input  logic     load,
  input  seg_ctr_t load_val,
  input  logic     step,
  output seg_ctr_t state,
  output logic     at_end
);
  assign at_end = (state.ptr == state.end_lim);

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      state <= SEG_INIT;
    end else if (load) begin
      state <= load_val;
    end else if (step) begin
      state.ptr <= at_end ? state.start_lim : ~state.ptr;
    end
  end
endmodule

// File: rtl/segptr_readback.sv
module segptr_readback
  import segptr_pkg::*;
#(
  parameter int CTRL_W = 16,
  parameter int STAT_W = 16
) (
  input  seg_ctr_t                   rd_state,
  input  seg_ctr_t                   wr_state,
  input  logic [STAT_W-1:0]          status_hi,
  output logic [CTRL_W+STAT_W-1:0]   word
);
  always_comb begin
    word = '0;
    word[RD_PTR_B]   = rd_state.ptr;
    word[RD_START_B] = rd_state.start_lim;
    word[RD_END_B]   = rd_state.end_lim;
    word[WR_PTR_B]   = wr_state.ptr;
    word[WR_START_B] = wr_state.start_lim;
    word[WR_END_B]   = wr_state.end_lim;
    word[CTRL_W +: STAT_W] = status_hi;
  end
endmodule

// File: rtl/segptr_bank.sv
module segptr_bank
  import segptr_pkg::*;
#(
  parameter int NUM_SETS = 2,
  parameter int CTRL_W   = 16,
  parameter int STAT_W   = 16,
  localparam int SET_W   = (NUM_SETS > 1) ? $clog2(NUM_SETS) : 1,
  localparam int DATA_W  = CTRL_W + STAT_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [SET_W-1:0]  set_sel,
  input  logic              reg_wr,
  input  logic [CTRL_W-1:0] reg_wr_data,
  input  logic              reg_rd,
  input  logic [STAT_W-1:0] status_hi,
  input  logic              rd_adv,
  input  logic              wr_adv,
  input  logic              seg_rst,
  output logic              rd_seg,
  output logic              wr_seg,
  output logic              rd_end_stb,
  output logic              wr_end_stb,
  output logic [DATA_W-1:0] rd_data
);
  seg_ctr_t rd_ld, wr_ld;
  seg_ctr_t rd_st [NUM_SETS];
  seg_ctr_t wr_st [NUM_SETS];
  logic     rd_at_end [NUM_SETS];
  logic     wr_at_end [NUM_SETS];
  logic [DATA_W-1:0] rb_word;

  // decode of the written control word
  always_comb begin
    rd_ld.ptr       = reg_wr_data[RD_PTR_B];
    rd_ld.start_lim = reg_wr_data[RD_START_B];
    rd_ld.end_lim   = reg_wr_data[RD_END_B];
    wr_ld.ptr       = reg_wr_data[WR_PTR_B];
    wr_ld.start_lim = reg_wr_data[WR_START_B];
    wr_ld.end_lim   = reg_wr_data[WR_END_B];
  end

  // reserved and constant-zero positions are intentionally dropped
  logic unused_wr_bits;
  assign unused_wr_bits = ^{reg_wr_data[CTRL_W-1:14], reg_wr_data[12], reg_wr_data[10],
                            reg_wr_data[9], reg_wr_data[7], reg_wr_data[5:4],
                            reg_wr_data[2:1]};

  generate
    for (genvar g = 0; g < NUM_SETS; g++) begin : g_set
      logic active;
      assign active = (set_sel == SET_W'(g));

      segptr_counter u_rd (
        .clk      (clk),
        .rst      (rst),
        .clr      (seg_rst && active),
        .load     (reg_wr && active),
        .load_val (rd_ld),
        .step     (rd_adv && active),
        .state    (rd_st[g]),
        .at_end   (rd_at_end[g])
      );

      segptr_counter u_wr (
        .clk      (clk),
        .rst      (rst),
        .clr      (seg_rst && active),
        .load     (reg_wr && active),
        .load_val (wr_ld),
        .step     (wr_adv && active),
        .state    (wr_st[g]),
        .at_end   (wr_at_end[g])
      );
    end
  endgenerate

  assign rd_seg = rd_st[set_sel].ptr;
  assign wr_seg = wr_st[set_sel].ptr;

  segptr_readback #(
    .CTRL_W (CTRL_W),
    .STAT_W (STAT_W)
  ) u_rb (
    .rd_state  (rd_st[set_sel]),
    .wr_state  (wr_st[set_sel]),
    .status_hi (status_hi),
    .word      (rb_word)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_end_stb <= 1'b0;
      wr_end_stb <= 1'b0;
      rd_data    <= '0;
    end else begin
      rd_end_stb <= rd_adv && rd_at_end[set_sel];
      wr_end_stb <= wr_adv && wr_at_end[set_sel];
      if (reg_rd) rd_data <= rb_word;
    end
  end
endmodule

// File: rtl/segptr_checker.sv
module segptr_checker #(
  parameter int SET_W  = 1,
  parameter int CTRL_W = 16,
  parameter int STAT_W = 16
) (
  input logic                     clk,
  input logic                     rst,
  input logic [SET_W-1:0]         set_sel,
  input logic                     reg_wr,
  input logic                     reg_rd,
  input logic [STAT_W-1:0]        status_hi,
  input logic                     rd_adv,
  input logic                     wr_adv,
  input logic                     seg_rst,
  input logic                     rd_seg,
  input logic                     wr_seg,
  input logic                     rd_end_stb,
  input logic                     wr_end_stb,
  input logic [CTRL_W+STAT_W-1:0] rd_data
);
  a_r1_reset_clears: assert property (@(posedge clk)
    rst |=> (rd_data == '0 && !rd_end_stb && !wr_end_stb));

  a_r2_zero_bits: assert property (@(posedge clk) disable iff (rst)
    (rd_data[15:0] & 16'hD6B6) == 16'h0000);

  a_r3_status_half: assert property (@(posedge clk) disable iff (rst)
    reg_rd |=> rd_data[CTRL_W +: STAT_W] == $past(status_hi));

  a_r4_step_moves: assert property (@(posedge clk) disable iff (rst)
    (rd_adv && !reg_wr && !seg_rst) |=>
      (rd_end_stb || rd_seg != $past(rd_seg) || set_sel != $past(set_sel)));

  a_r5_rd_holds: assert property (@(posedge clk) disable iff (rst)
    (!rd_adv && !reg_wr && !seg_rst) |=>
      (rd_seg == $past(rd_seg) || set_sel != $past(set_sel)));

  a_r5_wr_holds: assert property (@(posedge clk) disable iff (rst)
    (!wr_adv && !reg_wr && !seg_rst) |=>
      (wr_seg == $past(wr_seg) || set_sel != $past(set_sel)));

  a_r6_rd_stb_cause: assert property (@(posedge clk) disable iff (rst)
    rd_end_stb |-> $past(rd_adv));

  a_r6_wr_stb_cause: assert property (@(posedge clk) disable iff (rst)
    wr_end_stb |-> $past(wr_adv));

  a_r8_segrst_zero: assert property (@(posedge clk) disable iff (rst)
    seg_rst |=> ((!rd_seg && !wr_seg) || set_sel != $past(set_sel)));
endmodule

bind segptr_bank segptr_checker #(
  .SET_W  (SET_W),
  .CTRL_W (CTRL_W),
  .STAT_W (STAT_W)
) u_chk (.*);

// File: tb/sim_segptr_bank.sv
module sim_segptr_bank;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [0:0]  set_sel = '0;
  logic        reg_wr = 1'b0;
  logic [15:0] reg_wr_data = '0;
  logic        reg_rd = 1'b0;
  logic [15:0] status_hi = '0;
  logic        rd_adv = 1'b0;
  logic        wr_adv = 1'b0;
  logic        seg_rst = 1'b0;
  logic        rd_seg, wr_seg, rd_end_stb, wr_end_stb;
  logic [31:0] rd_data;

  int checks = 0;
  int errors = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  segptr_bank u0 (
    .clk(clk), .rst(rst), .set_sel(set_sel), .reg_wr(reg_wr),
    .reg_wr_data(reg_wr_data), .reg_rd(reg_rd), .status_hi(status_hi),
    .rd_adv(rd_adv), .wr_adv(wr_adv), .seg_rst(seg_rst),
    .rd_seg(rd_seg), .wr_seg(wr_seg), .rd_end_stb(rd_end_stb),
    .wr_end_stb(wr_end_stb), .rd_data(rd_data)
  );

  function automatic logic [15:0] enc(bit rp, bit rs, bit re, bit wp, bit ws, bit we);
    logic [15:0] w = '0;
    w[0] = rp; w[3] = rs; w[6] = re;
    w[8] = wp; w[11] = ws; w[13] = we;
    return w;
  endfunction

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic do_write(bit set, logic [15:0] val);
    @(negedge clk);
    set_sel = set; reg_wr = 1'b1; reg_wr_data = val;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic do_read(bit set, string req, logic [15:0] exp_lo);
    @(negedge clk);
    set_sel = set; reg_rd = 1'b1;
    @(negedge clk);
    reg_rd = 1'b0;
    chk(req, rd_data, {status_hi, exp_lo});
  endtask

  task automatic step(bit set, bit is_rd, string req, bit exp_seg, bit exp_stb);
    @(negedge clk);
    set_sel = set;
    if (is_rd) rd_adv = 1'b1; else wr_adv = 1'b1;
    @(negedge clk);
    rd_adv = 1'b0; wr_adv = 1'b0;
    if (is_rd) begin
      chk(req, {31'd0, rd_seg}, {31'd0, exp_seg});
      chk(req, {31'd0, rd_end_stb}, {31'd0, exp_stb});
    end else begin
      chk(req, {31'd0, wr_seg}, {31'd0, exp_seg});
      chk(req, {31'd0, wr_end_stb}, {31'd0, exp_stb});
    end
  endtask

  task automatic t_reset;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk("R1 rd_data", rd_data, 32'h0);
    chk("R1 strobes", {30'd0, rd_end_stb, wr_end_stb}, 32'h0);
    chk("R1 pointers", {30'd0, rd_seg, wr_seg}, 32'h0);
    do_read(1'b0, "R1 fg init", enc(0,0,1,0,0,1));
    do_read(1'b1, "R1 bg init", enc(0,0,1,0,0,1));
  endtask

  task automatic t_status;
    status_hi = 16'hA5C3;
    do_read(1'b0, "R3 status half", 16'h2040);
    status_hi = 16'h3C5A;
    do_read(1'b1, "R3 status half changed", 16'h2040);
  endtask

  task automatic t_advance;
    step(1'b0, 1'b1, "R4 rd step 0->1", 1'b1, 1'b0);
    chk("R5 wr untouched by rd_adv", {31'd0, wr_seg}, 32'h0);
    step(1'b0, 1'b1, "R4 rd wrap to start, R6 strobe", 1'b0, 1'b1);
    @(negedge clk);
    chk("R6 strobe one cycle", {31'd0, rd_end_stb}, 32'h0);
    step(1'b1, 1'b1, "R9 bg rd step", 1'b1, 1'b0);
    @(negedge clk);
    set_sel = 1'b0;
    #1;
    chk("R9 fg rd unchanged", {31'd0, rd_seg}, 32'h0);
  endtask

  task automatic t_bits;
    do_write(1'b0, 16'hFFFF);
    do_read(1'b0, "R2 field layout, zero bits", 16'h2949);
    do_read(1'b1, "R9 bg untouched by fg write", 16'h2041);
  endtask

  task automatic t_outside;
    do_write(1'b0, enc(0,1,1,0,0,0));
    do_read(1'b0, "R7 load outside range", 16'h0048);
    step(1'b0, 1'b1, "R7 step from outside value", 1'b1, 1'b0);
    step(1'b0, 1'b1, "R10 equal limits stay", 1'b1, 1'b1);
    step(1'b0, 1'b1, "R10 equal limits stay again", 1'b1, 1'b1);
  endtask

  task automatic t_wrwrap;
    do_write(1'b0, enc(0,0,0,1,0,0));
    step(1'b0, 1'b0, "R4 wr step 1->0 mod 2", 1'b0, 1'b0);
    chk("R5 rd untouched by wr_adv", {31'd0, rd_seg}, 32'h0);
    step(1'b0, 1'b0, "R6 wr strobe at end", 1'b0, 1'b1);
  endtask

  task automatic t_segrst;
    do_write(1'b1, 16'h2949);
    @(negedge clk);
    set_sel = 1'b1; seg_rst = 1'b1;
    @(negedge clk);
    seg_rst = 1'b0;
    do_read(1'b1, "R8 active set reset", 16'h2040);
    do_read(1'b0, "R8 inactive set kept", 16'h0000);
  endtask

  task automatic t_priority;
    @(negedge clk);
    set_sel = 1'b0; seg_rst = 1'b1; reg_wr = 1'b1; reg_wr_data = 16'h2949;
    @(negedge clk);
    seg_rst = 1'b0; reg_wr = 1'b0;
    do_read(1'b0, "R11 seg_rst over write", 16'h2040);
    @(negedge clk);
    reg_wr = 1'b1; reg_wr_data = enc(1,0,0,0,0,0); rd_adv = 1'b1;
    @(negedge clk);
    reg_wr = 1'b0; rd_adv = 1'b0;
    chk("R11 strobe from old state", {31'd0, rd_end_stb}, 32'h0);
    do_read(1'b0, "R11 write over advance", 16'h0001);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual=hung expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    t_reset();
    t_status();
    t_advance();
    t_bits();
    t_outside();
    t_wrwrap();
    t_segrst();
    t_priority();
    repeat (2) @(negedge clk);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule